// File: doc/BRIEF.md
# Byte-Lane Asynchronous Memory Core

A clocked, synthesizable stand-in for a 16-bit nonvolatile asynchronous memory with active-low controls: chip select, write strobe, output gate and one select per byte lane. On every rising clock edge the core samples its control pins and works out the operating mode. It then decides, lane by lane, whether that lane reads, writes or floats. Stored bytes live in an internal array whose depth is a parameter. The full-size part uses 18 address bits; the defaults here are kept small. Each output lane has its own drive flag, which stands in for a tri-state pad.

Writes are protected in two ways. A synchronous supply-low flag blocks every write while it is high. After reset, and again after every supply-low episode, a lockout also blocks writes. The lockout ends only after a run of consecutive clock samples in which both chip select and write strobe are high. Reads are allowed during the lockout. Read data and lane drive flags are registered, so they appear one clock after the controls are sampled.

Top module: `bytelane_mem`

## Requirements
- R1: When `cs_n` is sampled high, both bits of `lane_oe` are 0 one clock later, whatever the other inputs are.
- R2: With `cs_n` low and `we_n` high, sampling `oe_n` high, or both `lsel_n` and `usel_n` high, gives `lane_oe` = 2'b00 one clock later.
- R3: With `cs_n` low, `we_n` high and `oe_n` low, `lane_oe[0]` becomes the inverse of the sampled `lsel_n` and `lane_oe[1]` the inverse of the sampled `usel_n` one clock later. A driving lane shows the stored byte: lower lane on `rdata[7:0]`, upper lane on `rdata[15:8]`.
- R4: An accepted write (`cs_n` and `we_n` both low, `oe_n` ignored) stores `wdata[7:0]` when `lsel_n` is low and `wdata[15:8]` when `usel_n` is low. A lane whose select is high keeps its old contents.
- R5: A cycle sampled with `cs_n` and `we_n` both low gives `lane_oe` = 2'b00 one clock later, even with `oe_n` low.
- R6: After reset, writes are ignored until LOCK_CYCLES consecutive samples have `cs_n` and `we_n` both high. A sample with either of them low restarts the count, so a write after LOCK_CYCLES-1 idle samples is ignored and a write after LOCK_CYCLES idle samples is accepted.
- R7: While `supply_low` is high, no write is accepted. When it drops, the lockout of R6 starts again from zero.
- R8: A lane with its `lane_oe` bit at 0 shows 8'h00 on its byte of `rdata`.
- R9: A read sampled the cycle after an accepted write to the same address returns the newly written bytes.
- R10: While `rst_n` is low, `lane_oe` is 2'b00 and `rdata` is 16'h0000.

Parameter LOCK_CYCLES (default 500) is the lockout length of R6 in clock samples. Parameter DEPTH is the number of words in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; starts the lockout |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| lsel_n | input | 1 | Lower byte select, active low |
| usel_n | input | 1 | Upper byte select, active low |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| wdata | input | 16 | Write data |
| supply_low | input | 1 | Synchronous supply-low flag; blocks writes |
| rdata | output | 16 | Registered read data, 0 on floating lanes |
| lane_oe | output | 2 | Per-lane drive flag: bit 0 lower, bit 1 upper |

## Verification
Most internal state can only be seen at the ports through a later read. A lockout counter that ends early or late, or a lane that writes without being selected, shows up only when the affected word is read back. That read comes at least one clock after the faulty write, and it exposes the fault as a wrong byte on one lane. A wrong mode decode is seen sooner: it appears in `lane_oe` on the very next clock. The bench walks the lockout edge at exactly LOCK_CYCLES-1 and LOCK_CYCLES idle samples, with and without a supply-low episode. It also tracks a shadow copy of every written byte, so that a wrong lane in a write is caught on the next read of that word.

// File: rtl/bytelane_mem_pkg.sv
package bytelane_mem_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    // operating mode decoded from the sampled control pins
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,  // deselected
        MODE_OFF   = 2'd1,  // selected, outputs gated off
        MODE_READ  = 2'd2,
        MODE_WRITE = 2'd3
    } mode_e;

    // registered output bundle
    typedef struct packed {
        logic [LANES-1:0]  drive;
        logic [DATA_W-1:0] data;
    } out_s;

endpackage

// File: rtl/bytelane_mode_dec.sv
module bytelane_mode_dec
    import bytelane_mem_pkg::*;
(
    input  logic             cs_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] sel_n,
    output mode_e            mode,
    output logic [LANES-1:0] lane_rd,
    output logic [LANES-1:0] lane_wr
);

    always_comb begin
        if (cs_n)                mode = MODE_IDLE;
        else if (!we_n)          mode = MODE_WRITE;
        else if (oe_n || &sel_n) mode = MODE_OFF;
        else                     mode = MODE_READ;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_rd[g] = (mode == MODE_READ)  && !sel_n[g];
        assign lane_wr[g] = (mode == MODE_WRITE) && !sel_n[g];
    end

endmodule

// File: rtl/bytelane_lockout.sv
module bytelane_lockout #(
    parameter int LOCK_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,        // chip select and write strobe both high
    input  logic supply_low,
    output logic ready,
    output logic wr_ok
);

    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    typedef struct packed {
        logic          ready;
        logic [CW-1:0] cnt;
    } lk_s;

    lk_s lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (supply_low) begin
            lk_d.ready = 1'b0;
            lk_d.cnt   = '0;
        end else if (!lk_q.ready) begin
            if (!idle)               lk_d.cnt   = '0;
            else if (lk_q.cnt == LAST) lk_d.ready = 1'b1;
            else                     lk_d.cnt   = lk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign ready = lk_q.ready;
    assign wr_ok = lk_q.ready && !supply_low;

endmodule

// File: rtl/bytelane_array.sv
module bytelane_array
    import bytelane_mem_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wr_lane,
    output logic [DATA_W-1:0] rd_data
);

    // one bank per byte lane; contents are not reset (nonvolatile)
    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[addr];
    end

endmodule

// File: rtl/bytelane_mem.sv
module bytelane_mem
    import bytelane_mem_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int LOCK_CYCLES = 500,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          lsel_n,
    input  logic          usel_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    input  logic          supply_low,
    output logic [15:0]   rdata,
    output logic [1:0]    lane_oe
);

    mode_e             mode_w;
    logic [LANES-1:0]  lane_rd_w, lane_wr_w, wr_en_w;
    logic              ready_w, wr_ok_w;
    logic [DATA_W-1:0] arr_rd_w;
    out_s              out_d, out_q;

    bytelane_mode_dec u_dec (
        .cs_n    (cs_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .sel_n   ({usel_n, lsel_n}),
        .mode    (mode_w),
        .lane_rd (lane_rd_w),
        .lane_wr (lane_wr_w)
    );

    bytelane_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (cs_n && we_n),
        .supply_low (supply_low),
        .ready      (ready_w),
        .wr_ok      (wr_ok_w)
    );

    assign wr_en_w = lane_wr_w & {LANES{wr_ok_w}};

    bytelane_array #(.DEPTH(DEPTH)) u_arr (
        .clk     (clk),
        .addr    (addr),
        .wdata   (wdata),
        .wr_lane (wr_en_w),
        .rd_data (arr_rd_w)
    );

    always_comb begin
        out_d = '0;
        if (mode_w == MODE_READ) begin
            for (int i = 0; i < LANES; i++) begin
                out_d.drive[i] = lane_rd_w[i];
                out_d.data[i*LANE_W +: LANE_W] =
                    lane_rd_w[i] ? arr_rd_w[i*LANE_W +: LANE_W] : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rdata   = out_q.data;
    assign lane_oe = out_q.drive;

endmodule

// File: rtl/bytelane_mem_chk.sv
module bytelane_mem_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        we_n,
    input logic        oe_n,
    input logic        lsel_n,
    input logic        usel_n,
    input logic        supply_low,
    input logic        lock_ready,
    input logic [15:0] rdata,
    input logic [1:0]  lane_oe
);

    assert_deselect_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (lane_oe == 2'b00));

    assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && (oe_n || (lsel_n && usel_n))) |=> (lane_oe == 2'b00));

    assert_read_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n) |=> (lane_oe == ~$past({usel_n, lsel_n})));

    assert_write_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> (lane_oe == 2'b00));

    assert_supply_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !lock_ready);

    assert_float_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_oe[0] || rdata[7:0] == 8'h00) && (lane_oe[1] || rdata[15:8] == 8'h00)));

endmodule

bind bytelane_mem bytelane_mem_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .lsel_n     (lsel_n),
    .usel_n     (usel_n),
    .supply_low (supply_low),
    .lock_ready (ready_w),
    .rdata      (rdata),
    .lane_oe    (lane_oe)
);

// File: tb/test_bytelane_mem.sv
`timescale 1ns/1ps
module test_bytelane_mem;

    localparam int DEPTH = 64;
    localparam int LOCK  = 8;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lsel_n = 1'b1, usel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic supply_low = 1'b0;
    logic [15:0] rdata;
    logic [1:0]  lane_oe;

    int checks = 0;
    int errors = 0;

    // shadow model built from the requirements
    logic [15:0] m_mem  [DEPTH];
    logic [1:0]  m_know [DEPTH];
    logic        m_ready = 1'b0;
    int          m_cnt   = 0;

    always #2 clk = ~clk;

    bytelane_mem #(.DEPTH(DEPTH), .LOCK_CYCLES(LOCK)) i_bytelane_mem (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .lsel_n(lsel_n), .usel_n(usel_n), .addr(addr), .wdata(wdata),
        .supply_low(supply_low), .rdata(rdata), .lane_oe(lane_oe)
    );

    function automatic logic [1:0] exp_drive(logic c, logic w, logic o, logic l, logic u);
        return {!c && w && !o && !u, !c && w && !o && !l};
    endfunction

    function automatic string oe_tag(logic c, logic w, logic o, logic l, logic u);
        if (c)            return "R1";
        if (!w)           return "R5";
        if (o || (l && u)) return "R2";
        return "R3";
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one sampled cycle: drive at negedge, check at the following negedge
    task automatic step(logic c, logic w, logic o, logic l, logic u,
                        logic [AW-1:0] a, logic [15:0] wd, logic sl, string dtag);
        logic [1:0] ed;
        logic wr_ok;
        cs_n = c; we_n = w; oe_n = o; lsel_n = l; usel_n = u;
        addr = a; wdata = wd; supply_low = sl;
        ed    = exp_drive(c, w, o, l, u);
        wr_ok = m_ready && !sl;
        @(posedge clk);
        @(negedge clk);
        check(oe_tag(c, w, o, l, u), {14'd0, lane_oe}, {14'd0, ed});
        for (int i = 0; i < 2; i++) begin
            if (!ed[i])
                check("R8", {8'd0, rdata[i*8 +: 8]}, 16'd0);
            else if (m_know[a][i])
                check(dtag, {8'd0, rdata[i*8 +: 8]}, {8'd0, m_mem[a][i*8 +: 8]});
        end
        if (!c && !w && wr_ok) begin
            if (!l) begin m_mem[a][7:0]  = wd[7:0];  m_know[a][0] = 1'b1; end
            if (!u) begin m_mem[a][15:8] = wd[15:8]; m_know[a][1] = 1'b1; end
        end
        if (sl) begin
            m_ready = 1'b0; m_cnt = 0;
        end else if (!m_ready) begin
            if (!(c && w))          m_cnt = 0;
            else if (m_cnt == LOCK-1) m_ready = 1'b1;
            else                    m_cnt++;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1, 1, 1, 1, 1, '0, 16'h0, 0, "R1");
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        step(0, 1, 0, 0, 0, a, 16'h0, 0, tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_know[i] = 2'b00; end
        repeat (3) @(negedge clk);
        check("R10", {14'd0, lane_oe}, 16'd0);
        check("R10", rdata, 16'h0000);
        rst_n = 1'b1;

        // R6: write after LOCK-1 idle samples is ignored
        idle(LOCK - 1);
        step(0, 0, 1, 0, 0, 6'd1, 16'hDEAD, 0, "R6");
        idle(LOCK);
        step(0, 0, 0, 0, 0, 6'd1, 16'h1111, 0, "R6");   // accepted, oe_n low: R5
        rd(6'd1, "R6");
        // R6 negative: earlier ignored write did not land (model holds 1111)
        check("R6", m_mem[1], 16'h1111);

        // R4: byte lanes
        step(0, 0, 1, 0, 1, 6'd1, 16'hAB22, 0, "R4");
        rd(6'd1, "R4");
        step(0, 0, 0, 1, 0, 6'd1, 16'h33CD, 0, "R4");
        rd(6'd1, "R4");
        step(0, 1, 0, 0, 1, 6'd1, 16'h0, 0, "R3");
        step(0, 1, 0, 1, 0, 6'd1, 16'h0, 0, "R3");
        step(0, 1, 1, 0, 0, 6'd1, 16'h0, 0, "R2");
        step(0, 1, 0, 1, 1, 6'd1, 16'h0, 0, "R2");

        // R9: back-to-back write then read
        step(0, 0, 1, 0, 0, 6'd9, 16'h5A5A, 0, "R9");
        rd(6'd9, "R9");

        // R7: supply low blocks writes, then lockout restarts
        step(0, 0, 0, 0, 0, 6'd9, 16'hFFFF, 1, "R7");
        rd(6'd9, "R7");
        idle(LOCK - 1);
        step(0, 0, 1, 0, 0, 6'd9, 16'hEEEE, 0, "R7");
        rd(6'd9, "R7");
        idle(LOCK);
        step(0, 0, 1, 0, 0, 6'd9, 16'h7777, 0, "R7");
        rd(6'd9, "R7");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic c, w, o, l, u, sl;
            logic [AW-1:0] a;
            c  = ($urandom_range(0, 9) < 2);
            w  = ($urandom_range(0, 9) < 6);
            o  = ($urandom_range(0, 9) < 2);
            l  = $urandom_range(0, 1);
            u  = $urandom_range(0, 1);
            sl = ($urandom_range(0, 99) == 0);
            a  = AW'($urandom_range(0, 15));
            step(c, w, o, l, u, a, 16'($urandom), sl, w ? "R3" : "R4");
            if (sl) idle(LOCK + 1);
        end
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
    end

endmodule